// File: doc/BRIEF.md
# Two-Unit Reservation Station Scheduler

This block holds renamed instructions that are waiting for their source operands and sends them to two execution units. It has eight entries. Each entry stores an opcode, a destination tag, two source tags, a ready bit for each source, and a unit-select bit. When an instruction is allocated, its source ready bits are taken from a per-register busy table. Later, a result bus that carries two tags per cycle marks matching sources ready and clears matching busy bits.

In each cycle the block picks, for each unit, the oldest entry steered to that unit whose operands are all present. It sends at most one instruction per unit per cycle, using valid/ready handshakes. A configuration bit chooses the dispatch order. In strict order, an older entry that is still waiting on an operand holds back every younger entry. In free order, younger ready entries may pass it.

A second configuration bit lets an arriving ready instruction go straight to its unit when the station is empty. Without this bit, every instruction spends at least one cycle in an entry. A full output tells the allocation source to stop, and a flush input empties the station.

Top module: `rsv_sched`

## Requirements
- R1: After reset, and in the cycle after a flush, the station holds no entries, `full` is low, and every register in the busy table reads as present.
- R2: An entry is dispatched only when both of its sources are ready. When an instruction is allocated, its destination register is marked busy. The register stays busy until that tag appears on the result bus. A source that names a busy register starts out not ready.
- R3: A valid tag on either of the two result-bus lanes marks every matching waiting source ready and clears that register's busy bit. An instruction allocated in the same cycle as the broadcast sees the tag as present.
- R4: When several entries for the same unit are ready, the one allocated earliest is dispatched first.
- R5: When `cfg_inorder` is 1 (strict order), an entry is not dispatched while any older entry in the station still has a source that is not ready.
- R6: When `cfg_inorder` is 0 (free order), a ready entry is dispatched even if older entries are still waiting on operands.
- R7: `alloc_unit` = 0 steers an instruction to unit 0 (`eu0_*`), and 1 steers it to unit 1 (`eu1_*`). Each unit receives at most one instruction per cycle.
- R8: An offered instruction leaves the station only in a cycle where that unit's valid and ready are both high. While ready is low, valid stays high.
- R9: When `cfg_bypass` is 0, an instruction allocated into an empty station is offered to its unit no earlier than the next cycle.
- R10: When `cfg_bypass` is 1, the station is empty and both sources of the arriving instruction are ready, the instruction is offered to its unit in the same cycle. If that unit accepts it, no entry is written. Otherwise the instruction is stored.
- R11: `full` is high when all 8 entries are occupied. Allocation requests are ignored while it is high.
- R12: In a cycle with `flush` high, both units see valid low and the allocation request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the station and the busy table |
| cfg_inorder | input | 1 | 1 = strict dispatch order, 0 = free order |
| cfg_bypass | input | 1 | 1 = allow empty-station bypass |
| alloc_valid | input | 1 | Allocation request |
| alloc_unit | input | 1 | Target unit of the new instruction |
| alloc_op | input | 6 | Opcode |
| alloc_dst | input | 4 | Destination register tag |
| alloc_src0 | input | 4 | First source register tag |
| alloc_src1 | input | 4 | Second source register tag |
| full | output | 1 | No free entry |
| bc_valid | input | 2 | Per-lane result broadcast valid |
| bc_tag | input | 8 | Broadcast tags, lane 0 in the low nibble |
| eu0_valid | output | 1 | Instruction offered to unit 0 |
| eu0_ready | input | 1 | Unit 0 accepts |
| eu0_op | output | 6 | Opcode to unit 0 |
| eu0_dst | output | 4 | Destination tag to unit 0 |
| eu1_valid | output | 1 | Instruction offered to unit 1 |
| eu1_ready | input | 1 | Unit 1 accepts |
| eu1_op | output | 6 | Opcode to unit 1 |
| eu1_dst | output | 4 | Destination tag to unit 1 |

## Verification
Directed sequences each isolate one behaviour:
- A producer followed by a dependent consumer separates the busy-table check from the wake-up.
- A broadcast in the allocation cycle shows whether same-cycle forwarding works.
- An older waiting entry ahead of a younger ready one tells strict order apart from free order.
- Filling the station with both units stalled, then releasing them, exposes the full limit, the holding of valid, and the order of draining.
- Single arrivals into an empty station, with bypass off and then on, and with the target unit stalled, tell residency, bypass and the fall-back to storage apart.

After these, a long seeded random mix of allocations, broadcasts, stalls, flushes and mode changes is compared cycle by cycle against an age-ordered list model kept in the bench.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int RS_UNITS = 2;

  typedef enum logic {
    ORD_FREE   = 1'b0,
    ORD_STRICT = 1'b1
  } ord_e;
endpackage

// File: rtl/rsv_scoreboard.sv
module rsv_scoreboard #(
  parameter int TAGW = 4,
  parameter int NBC  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                set_en,
  input  logic [TAGW-1:0]     set_tag,
  input  logic [NBC-1:0]      bc_valid,
  input  logic [NBC*TAGW-1:0] bc_tag,
  input  logic [TAGW-1:0]     q0,
  input  logic [TAGW-1:0]     q1,
  output logic                q0_rdy,
  output logic                q1_rdy
);
  localparam int NREG = 1 << TAGW;

  logic [NREG-1:0] busy, busy_nx;

  function automatic logic heard(input logic [TAGW-1:0] t);
    logic h;
    h = 1'b0;
    for (int k = 0; k < NBC; k++)
      if (bc_valid[k] && bc_tag[k*TAGW +: TAGW] == t) h = 1'b1;
    return h;
  endfunction

  always_comb begin
    busy_nx = busy;
    for (int k = 0; k < NBC; k++)
      if (bc_valid[k]) busy_nx[bc_tag[k*TAGW +: TAGW]] = 1'b0;
    if (set_en) busy_nx[set_tag] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) busy <= '0;
    else                 busy <= busy_nx;
  end

  assign q0_rdy = !busy[q0] || heard(q0);
  assign q1_rdy = !busy[q1] || heard(q1);
endmodule

// File: rtl/rsv_oldest.sv
module rsv_oldest #(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0]            req,
  input  logic [DEPTH-1:0][DEPTH-1:0] older_of,
  output logic [DEPTH-1:0]            gnt
);
  function automatic logic none_older(input logic [DEPTH-1:0] r,
                                      input logic [DEPTH-1:0] row);
    return (r & row) == '0;
  endfunction

  always_comb
    for (int i = 0; i < DEPTH; i++)
      gnt[i] = req[i] && none_older(req, older_of[i]);
endmodule

// File: rtl/rsv_sched.sv
module rsv_sched #(
  parameter int DEPTH = 8,
  parameter int TAGW  = 4,
  parameter int OPW   = 6,
  parameter int NBC   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                cfg_inorder,
  input  logic                cfg_bypass,
  input  logic                alloc_valid,
  input  logic                alloc_unit,
  input  logic [OPW-1:0]      alloc_op,
  input  logic [TAGW-1:0]     alloc_dst,
  input  logic [TAGW-1:0]     alloc_src0,
  input  logic [TAGW-1:0]     alloc_src1,
  output logic                full,
  input  logic [NBC-1:0]      bc_valid,
  input  logic [NBC*TAGW-1:0] bc_tag,
  output logic                eu0_valid,
  input  logic                eu0_ready,
  output logic [OPW-1:0]      eu0_op,
  output logic [TAGW-1:0]     eu0_dst,
  output logic                eu1_valid,
  input  logic                eu1_ready,
  output logic [OPW-1:0]      eu1_op,
  output logic [TAGW-1:0]     eu1_dst
);
  import rsv_pkg::*;
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NU   = RS_UNITS;

  logic [DEPTH-1:0]            e_vld, e_unit, e_r0, e_r1;
  logic [OPW-1:0]              e_op  [DEPTH];
  logic [TAGW-1:0]             e_dst [DEPTH];
  logic [TAGW-1:0]             e_s0  [DEPTH];
  logic [TAGW-1:0]             e_s1  [DEPTH];
  logic [DEPTH-1:0][DEPTH-1:0] older_of;

  logic             new_r0, new_r1, alloc_fire, stn_empty;
  logic             byp_fire, byp_take, wr_en;
  logic [IDXW-1:0]  free_idx;
  logic [DEPTH-1:0] blocked, leave;
  logic [DEPTH-1:0] req [NU];
  logic [DEPTH-1:0] gnt [NU];
  logic [NU-1:0]    u_valid, u_ready;
  logic [OPW-1:0]   u_op  [NU];
  logic [TAGW-1:0]  u_dst [NU];
  logic [DEPTH-1:0] gnt0_w, gnt1_w;

  function automatic logic bc_hit(input logic [TAGW-1:0] t);
    logic h;
    h = 1'b0;
    for (int k = 0; k < NBC; k++)
      if (bc_valid[k] && bc_tag[k*TAGW +: TAGW] == t) h = 1'b1;
    return h;
  endfunction

  rsv_scoreboard #(.TAGW(TAGW), .NBC(NBC)) u_sb (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .set_en(alloc_fire), .set_tag(alloc_dst),
    .bc_valid(bc_valid), .bc_tag(bc_tag),
    .q0(alloc_src0), .q1(alloc_src1),
    .q0_rdy(new_r0), .q1_rdy(new_r1)
  );

  assign full       = &e_vld;
  assign stn_empty  = ~|e_vld;
  assign alloc_fire = alloc_valid && !full && !flush;
  assign byp_fire   = cfg_bypass && alloc_fire && stn_empty && new_r0 && new_r1;
  assign u_ready    = {eu1_ready, eu0_ready};
  assign byp_take   = byp_fire && u_ready[alloc_unit];
  assign wr_en      = alloc_fire && !byp_take;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!e_vld[i]) free_idx = IDXW'(i);
  end

  always_comb
    for (int i = 0; i < DEPTH; i++)
      blocked[i] = |(older_of[i] & e_vld & ~(e_r0 & e_r1));

  for (genvar u = 0; u < NU; u++) begin : g_unit
    always_comb
      for (int i = 0; i < DEPTH; i++)
        req[u][i] = e_vld[i] && e_r0[i] && e_r1[i] && (e_unit[i] == 1'(u))
                    && !(ord_e'(cfg_inorder) == ORD_STRICT && blocked[i]);

    rsv_oldest #(.DEPTH(DEPTH)) u_pick (
      .req(req[u]), .older_of(older_of), .gnt(gnt[u])
    );

    always_comb begin
      u_op[u]  = '0;
      u_dst[u] = '0;
      if (byp_fire && alloc_unit == 1'(u)) begin
        u_op[u]  = alloc_op;
        u_dst[u] = alloc_dst;
      end else begin
        for (int i = 0; i < DEPTH; i++)
          if (gnt[u][i]) begin
            u_op[u]  = u_op[u]  | e_op[i];
            u_dst[u] = u_dst[u] | e_dst[i];
          end
      end
    end

    assign u_valid[u] = !flush && ((|gnt[u]) || (byp_fire && alloc_unit == 1'(u)));
  end

  assign leave = (gnt[0] & {DEPTH{u_ready[0]}}) | (gnt[1] & {DEPTH{u_ready[1]}});

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      e_vld    <= '0;
      older_of <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && free_idx == IDXW'(i)) begin
          e_vld[i]    <= 1'b1;
          e_unit[i]   <= alloc_unit;
          e_op[i]     <= alloc_op;
          e_dst[i]    <= alloc_dst;
          e_s0[i]     <= alloc_src0;
          e_s1[i]     <= alloc_src1;
          e_r0[i]     <= new_r0;
          e_r1[i]     <= new_r1;
          older_of[i] <= e_vld;
        end else begin
          if (leave[i]) e_vld[i] <= 1'b0;
          if (bc_hit(e_s0[i])) e_r0[i] <= 1'b1;
          if (bc_hit(e_s1[i])) e_r1[i] <= 1'b1;
          if (wr_en) older_of[i][free_idx] <= 1'b0;
        end
      end
    end
  end

  assign gnt0_w    = gnt[0];
  assign gnt1_w    = gnt[1];
  assign eu0_valid = u_valid[0];
  assign eu0_op    = u_op[0];
  assign eu0_dst   = u_dst[0];
  assign eu1_valid = u_valid[1];
  assign eu1_op    = u_op[1];
  assign eu1_dst   = u_dst[1];
endmodule

// File: rtl/rsv_sched_chk.sv
module rsv_sched_chk #(
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             full,
  input logic             wr_en,
  input logic             byp_fire,
  input logic [DEPTH-1:0] e_vld,
  input logic [DEPTH-1:0] e_r0,
  input logic [DEPTH-1:0] e_r1,
  input logic [DEPTH-1:0] gnt0_w,
  input logic [DEPTH-1:0] gnt1_w,
  input logic             eu0_valid,
  input logic             eu0_ready,
  input logic             eu1_valid,
  input logic             eu1_ready
);
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (e_vld == '0)); // R1
  AST_GRANT_HAS_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt0_w | gnt1_w) & ~(e_vld & e_r0 & e_r1)) == '0); // R2
  AST_ONE_PER_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt0_w) && $onehot0(gnt1_w) && (gnt0_w & gnt1_w) == '0); // R7
  AST_HOLD_UNIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (eu0_valid && !eu0_ready && !flush) |=> (eu0_valid || flush)); // R8
  AST_HOLD_UNIT1: assert property (@(posedge clk) disable iff (!rst_n)
    (eu1_valid && !eu1_ready && !flush) |=> (eu1_valid || flush)); // R8
  AST_EMPTY_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (e_vld == '0 && !byp_fire) |-> (!eu0_valid && !eu1_valid)); // R9
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (!wr_en && !byp_fire)); // R11
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!eu0_valid && !eu1_valid && !wr_en)); // R12
endmodule

bind rsv_sched rsv_sched_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .full(full), .wr_en(wr_en),
  .byp_fire(byp_fire), .e_vld(e_vld), .e_r0(e_r0), .e_r1(e_r1),
  .gnt0_w(gnt0_w), .gnt1_w(gnt1_w),
  .eu0_valid(eu0_valid), .eu0_ready(eu0_ready),
  .eu1_valid(eu1_valid), .eu1_ready(eu1_ready)
);

// File: tb/sim_rsv_sched.sv
module sim_rsv_sched;
  localparam int D = 8, TW = 4, OW = 6;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, inord = 1'b0, byp = 1'b0;
  logic av = 1'b0, au = 1'b0;
  logic [OW-1:0] aop = '0;
  logic [TW-1:0] adst = '0, as0 = '0, as1 = '0;
  logic full;
  logic [1:0] bcv = '0;
  logic [2*TW-1:0] bct = '0;
  logic v0, v1, rd0 = 1'b1, rd1 = 1'b1;
  logic [OW-1:0] op0, op1;
  logic [TW-1:0] d0, d1;

  always #2 clk = ~clk;

  rsv_sched #(.DEPTH(D), .TAGW(TW), .OPW(OW), .NBC(2)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cfg_inorder(inord), .cfg_bypass(byp),
    .alloc_valid(av), .alloc_unit(au), .alloc_op(aop), .alloc_dst(adst),
    .alloc_src0(as0), .alloc_src1(as1), .full(full), .bc_valid(bcv), .bc_tag(bct),
    .eu0_valid(v0), .eu0_ready(rd0), .eu0_op(op0), .eu0_dst(d0),
    .eu1_valid(v1), .eu1_ready(rd1), .eu1_op(op1), .eu1_dst(d1)
  );

  int total = 0, bad = 0;
  string tag = "R1";

  // age-ordered model: index 0 is the oldest entry
  int m_n = 0;
  int m_op[D], m_unit[D], m_dst[D], m_s0[D], m_s1[D];
  bit m_r0[D], m_r1[D];
  bit busy[16];
  int pk[2];
  bit ev[2];
  int eop[2], edst[2];
  bit e_fire, e_byp, n0r, n1r;

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit heard(int t);
    return (bcv[0] && int'(bct[TW-1:0]) == t) || (bcv[1] && int'(bct[2*TW-1:TW]) == t);
  endfunction

  task automatic expect_now();
    bit blk;
    e_fire = av && (m_n < D) && !flush;
    n0r = !busy[int'(as0)] || heard(int'(as0));
    n1r = !busy[int'(as1)] || heard(int'(as1));
    e_byp = byp && e_fire && (m_n == 0) && n0r && n1r;
    for (int u = 0; u < 2; u++) begin
      pk[u] = -1;
      blk = 0;
      for (int k = 0; k < m_n; k++) begin
        if (pk[u] < 0 && m_r0[k] && m_r1[k] && m_unit[k] == u && !(inord && blk)) pk[u] = k;
        if (!(m_r0[k] && m_r1[k])) blk = 1;
      end
      ev[u] = !flush && (pk[u] >= 0 || (e_byp && int'(au) == u));
      if (e_byp && int'(au) == u) begin
        eop[u] = int'(aop); edst[u] = int'(adst);
      end else if (pk[u] >= 0) begin
        eop[u] = m_op[pk[u]]; edst[u] = m_dst[pk[u]];
      end
    end
    chk("full", int'(full), int'(m_n == D));
    chk("eu0_valid", int'(v0), int'(ev[0]));
    chk("eu1_valid", int'(v1), int'(ev[1]));
    if (ev[0]) begin chk("eu0_op", int'(op0), eop[0]); chk("eu0_dst", int'(d0), edst[0]); end
    if (ev[1]) begin chk("eu1_op", int'(op1), eop[1]); chk("eu1_dst", int'(d1), edst[1]); end
  endtask

  task automatic model_upd();
    bit rm[D];
    int w;
    bit rdy[2];
    rdy[0] = rd0; rdy[1] = rd1;
    if (flush) begin
      m_n = 0;
      for (int r = 0; r < 16; r++) busy[r] = 0;
      return;
    end
    for (int k = 0; k < D; k++) rm[k] = 0;
    for (int u = 0; u < 2; u++)
      if (ev[u] && rdy[u] && pk[u] >= 0 && !(e_byp && int'(au) == u)) rm[pk[u]] = 1;
    w = 0;
    for (int k = 0; k < m_n; k++)
      if (!rm[k]) begin
        m_op[w] = m_op[k]; m_unit[w] = m_unit[k]; m_dst[w] = m_dst[k];
        m_s0[w] = m_s0[k]; m_s1[w] = m_s1[k];
        m_r0[w] = m_r0[k] || heard(m_s0[k]);
        m_r1[w] = m_r1[k] || heard(m_s1[k]);
        w++;
      end
    m_n = w;
    if (bcv[0]) busy[int'(bct[TW-1:0])] = 0;
    if (bcv[1]) busy[int'(bct[2*TW-1:TW])] = 0;
    if (e_fire && !(e_byp && rdy[int'(au)])) begin
      m_op[m_n] = int'(aop); m_unit[m_n] = int'(au); m_dst[m_n] = int'(adst);
      m_s0[m_n] = int'(as0); m_s1[m_n] = int'(as1);
      m_r0[m_n] = n0r; m_r1[m_n] = n1r;
      m_n++;
    end
    if (e_fire) busy[int'(adst)] = 1;
  endtask

  task automatic step();
    #1;
    expect_now();
    @(posedge clk);
    model_upd();
    @(negedge clk);
  endtask

  task automatic idle();
    av = 0; bcv = '0; flush = 0; rd0 = 1; rd1 = 1;
  endtask

  task automatic put(int u, int op, int dst, int s0, int s1);
    av = 1; au = 1'(u); aop = OW'(op); adst = TW'(dst); as0 = TW'(s0); as1 = TW'(s1);
  endtask

  task automatic bc(int k, int t);
    bcv[k] = 1'b1;
    bct[k*TW +: TW] = TW'(t);
  endtask

  task automatic clr();
    idle(); flush = 1; step(); flush = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R7 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int r = 0; r < 16; r++) busy[r] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: empty after reset, busy table clear (bypass proves operands present)
    tag = "R1"; idle(); step();
    byp = 1; put(0, 1, 8, 3, 4); step(); idle(); step();
    // R11 then R8 then R4: fill with both units stalled, hold, drain in age order
    tag = "R11"; clr(); byp = 0; rd0 = 0; rd1 = 0;
    for (int k = 0; k < 10; k++) begin put(k % 2, 10 + k, 8 + (k % 8), 0, 0); step(); end
    av = 0;
    tag = "R8"; repeat (3) step();
    tag = "R4"; rd0 = 1; rd1 = 1; repeat (6) step();
    // R2: dependent consumer waits for producer broadcast
    tag = "R2"; clr();
    put(0, 30, 5, 0, 0); step();
    put(1, 31, 9, 5, 0); step(); av = 0; repeat (2) step();
    tag = "R3"; bc(0, 5); step(); bcv = '0; step();
    put(0, 32, 6, 0, 0); step();
    put(1, 33, 7, 6, 6); bc(1, 6); step(); idle(); repeat (2) step();
    // R5 / R6: older waiting entry ahead of younger ready one
    for (int md = 0; md < 2; md++) begin
      tag = (md == 0) ? "R5" : "R6";
      clr(); inord = (md == 0);
      put(0, 40, 9, 0, 0); step();
      put(0, 41, 10, 9, 0); step();
      put(1, 42, 11, 0, 0); step(); av = 0; repeat (3) step();
      bc(0, 9); step(); bcv = '0; repeat (3) step();
    end
    inord = 0;
    // R9: no bypass, minimum residency
    tag = "R9"; clr(); byp = 0; put(1, 50, 12, 0, 0); step(); av = 0; repeat (2) step();
    // R10: bypass taken, bypass refused by stalled unit, bypass not possible
    tag = "R10"; clr(); byp = 1;
    put(1, 51, 12, 0, 0); step();
    rd1 = 0; put(1, 52, 13, 0, 0); step(); av = 0; rd1 = 1; repeat (2) step();
    put(0, 53, 14, 13, 0); step(); av = 0; bc(0, 13); step(); bcv = '0; repeat (2) step();
    // R12: flush cycle blocks offers and allocation
    tag = "R12"; clr(); byp = 0; rd0 = 0; rd1 = 0;
    put(0, 60, 1, 0, 0); step(); put(1, 61, 2, 0, 0); step();
    flush = 1; put(0, 62, 3, 0, 0); rd0 = 1; rd1 = 1; step();
    flush = 0; av = 0; repeat (2) step();
    // R7: random traffic
    tag = "R7"; clr();
    for (int c = 0; c < 4000; c++) begin
      if (c % 500 == 0) begin inord = 1'($urandom); byp = 1'($urandom); end
      av = ($urandom % 10) < 6; au = 1'($urandom);
      aop = OW'($urandom); adst = TW'($urandom);
      as0 = TW'($urandom); as1 = TW'($urandom);
      bcv = 2'($urandom); bct = (2*TW)'($urandom);
      rd0 = ($urandom % 10) < 7; rd1 = ($urandom % 10) < 7;
      flush = ($urandom % 100) == 0;
      step();
    end
    idle(); step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule